// File: doc/BRIEF.md
# Tournament Branch Predictor Chooser

This block combines two component branch predictors through a per-address selector. A table of 2-bit saturating selector counters, indexed by the branch's instruction word address, records which component has been more accurate for that branch. The selector's MSB decides which component's prediction becomes the final one. So that the block can be exercised on its own, it contains both components. Component A is a bimodal table indexed by address. Component B is a gshare table indexed by address XOR global history, and it is twice the size of the bimodal table, so the three tables together hold a power-of-two number of counters.

A prediction request presents a word address and returns, two cycles later, the final direction, the selector's choice and both component predictions. At commit, the pipeline returns the branch address, the actual outcome and the two component predictions that were made for it. Both components always train on the outcome. The selector trains only when the two components disagreed, and it moves toward the one that was right. After reset, the block sweeps every table entry to its initial value and then raises its ready flag.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, rdy and out_valid are low. rdy rises exactly 2^GSH_W clock edges after reset is released (2048 with defaults). From then on every component counter and every selector counter holds 01, and the global history is 0.
- R2: While rdy is low, pred_valid produces no out_valid, and commit_valid changes no table and no history.
- R3: A request with pred_valid high at clock edge k, while rdy is high, produces out_valid high for exactly one cycle after edge k+1. Its results reflect table and history state from before edge k, so a commit at edge k is not visible to that request.
- R4: Component A reads the bimodal counter indexed by the low BIM_W bits of the address. It predicts taken (out_pred_a = 1) when that counter is 2 or 3.
- R5: Component B reads the gshare counter indexed by the low GSH_W bits of the address XOR the GSH_W-bit global history. It predicts taken when that counter is 2 or 3.
- R6: Each accepted commit shifts its actual outcome into bit 0 of the global history, and the older bits move up by one. The gshare index used to train that commit is formed from the history before the shift.
- R7: The selector counter is indexed by the low SEL_W bits of the address. out_sel_b equals its MSB. out_taken equals out_pred_b when out_sel_b is 1, and out_pred_a otherwise.
- R8: On an accepted commit with commit_pred_a different from commit_pred_b, the selector increments (saturating at 3) when commit_pred_b matches the outcome, and decrements (saturating at 0) otherwise. When the two agree, the selector is unchanged.
- R9: On every accepted commit, whatever the selector holds, the bimodal and gshare counters addressed by that commit increment (saturating at 3) when the outcome is taken, and decrement (saturating at 0) when it is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Prediction request |
| pred_addr | input | ADDR_W | Word address of the branch being predicted |
| commit_valid | input | 1 | Commit of a resolved branch |
| commit_addr | input | ADDR_W | Word address of the committed branch |
| commit_taken | input | 1 | Actual outcome, 1 = taken |
| commit_pred_a | input | 1 | Component A prediction made for that branch |
| commit_pred_b | input | 1 | Component B prediction made for that branch |
| rdy | output | 1 | Initialisation sweep finished |
| out_valid | output | 1 | Prediction result valid |
| out_taken | output | 1 | Final predicted direction |
| out_sel_b | output | 1 | 1 when component B was chosen |
| out_pred_a | output | 1 | Component A prediction |
| out_pred_b | output | 1 | Component B prediction |

## Verification
Prediction results appear after the second clock edge following the request. A commit changes the tables and history at the edge where it is sampled, so a request at that same edge still sees the older state. The bench drives inputs on the falling edge and advances its own table model at the matching rising edge. On the next falling edge it compares the outputs with the model's entry for the request made one step earlier. The ready flag is checked against a count of edges since reset on every step. Directed sequences check selector saturation, agreement, history effects and the same-edge case against hand-derived values, two steps after each request.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_LO = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == CTR_MAX) ? CTR_MAX : ctr_t'(c + 2'd1);
    else    return (c == CTR_MIN) ? CTR_MIN : ctr_t'(c - 2'd1);
  endfunction

endpackage

// File: rtl/tp_sweep.sv
module tp_sweep #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  output logic         busy,
  output logic [W-1:0] idx
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + 1'b1;
    end
  end

  // once the sweep has ended it stays ended until the next reset
  p_sweep_done_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], bit_in};
  end

  p_hist_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));

endmodule

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int   IDX_W = 10,
  parameter ctr_t INIT  = CTR_WEAK_LO
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_dir
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];
  ctr_t up_old;
  ctr_t up_new;

  always_comb begin
    up_old = mem[up_idx];
    up_new = ctr_step(up_old, up_dir);
  end

  always_ff @(posedge clk) begin
    if (clr_en)     mem[clr_idx] <= INIT;
    else if (up_en) mem[up_idx]  <= up_new;
  end

  // read-first port: a write at the same edge is not seen
  always_ff @(posedge clk) begin
    if (rd_en) rd_msb <= mem[rd_idx][1];
  end

  // saturation at both ends
  p_sat_hi_r9: assert property (@(posedge clk) disable iff (rst || clr_en)
    (up_en && up_dir && up_old == CTR_MAX) |=> (mem[$past(up_idx)] == CTR_MAX));
  p_sat_lo_r9: assert property (@(posedge clk) disable iff (rst || clr_en)
    (up_en && !up_dir && up_old == CTR_MIN) |=> (mem[$past(up_idx)] == CTR_MIN));

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int SEL_W = 10,
  parameter int BIM_W = 10,
  localparam int GSH_W  = BIM_W + 1,
  localparam int ADDR_W = (SEL_W > GSH_W) ? SEL_W : GSH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_valid,
  input  logic [ADDR_W-1:0] pred_addr,
  input  logic              commit_valid,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic              commit_taken,
  input  logic              commit_pred_a,
  input  logic              commit_pred_b,
  output logic              rdy,
  output logic              out_valid,
  output logic              out_taken,
  output logic              out_sel_b,
  output logic              out_pred_a,
  output logic              out_pred_b
);
  localparam int SWP_W = ADDR_W;

  logic             busy;
  logic [SWP_W-1:0] swp_idx;
  logic [GSH_W-1:0] ghist;
  logic             acc_p, acc_c;
  logic             s1_v;
  logic             bim_q, gsh_q, sel_q;
  logic [GSH_W-1:0] gsh_ridx, gsh_uidx;
  logic             sel_up_en, sel_up_dir;

  assign rdy   = ~busy;
  assign acc_p = pred_valid & ~busy;
  assign acc_c = commit_valid & ~busy;

  assign gsh_ridx   = pred_addr[GSH_W-1:0] ^ ghist;
  assign gsh_uidx   = commit_addr[GSH_W-1:0] ^ ghist;
  assign sel_up_en  = acc_c & (commit_pred_a != commit_pred_b);
  assign sel_up_dir = (commit_pred_b == commit_taken);

  tp_sweep #(.W(SWP_W)) u_sweep (
    .clk (clk),
    .rst (rst),
    .busy(busy),
    .idx (swp_idx)
  );

  tp_ghist #(.W(GSH_W)) u_ghist (
    .clk     (clk),
    .rst     (rst),
    .shift_en(acc_c),
    .bit_in  (commit_taken),
    .hist    (ghist)
  );

  tp_ctr_table #(.IDX_W(BIM_W), .INIT(CTR_WEAK_LO)) u_bim (
    .clk    (clk),
    .rst    (rst),
    .clr_en (busy),
    .clr_idx(swp_idx[BIM_W-1:0]),
    .rd_en  (acc_p),
    .rd_idx (pred_addr[BIM_W-1:0]),
    .rd_msb (bim_q),
    .up_en  (acc_c),
    .up_idx (commit_addr[BIM_W-1:0]),
    .up_dir (commit_taken)
  );

  tp_ctr_table #(.IDX_W(GSH_W), .INIT(CTR_WEAK_LO)) u_gsh (
    .clk    (clk),
    .rst    (rst),
    .clr_en (busy),
    .clr_idx(swp_idx[GSH_W-1:0]),
    .rd_en  (acc_p),
    .rd_idx (gsh_ridx),
    .rd_msb (gsh_q),
    .up_en  (acc_c),
    .up_idx (gsh_uidx),
    .up_dir (commit_taken)
  );

  tp_ctr_table #(.IDX_W(SEL_W), .INIT(CTR_WEAK_LO)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .clr_en (busy),
    .clr_idx(swp_idx[SEL_W-1:0]),
    .rd_en  (acc_p),
    .rd_idx (pred_addr[SEL_W-1:0]),
    .rd_msb (sel_q),
    .up_en  (sel_up_en),
    .up_idx (commit_addr[SEL_W-1:0]),
    .up_dir (sel_up_dir)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= acc_p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_taken  <= 1'b0;
      out_sel_b  <= 1'b0;
      out_pred_a <= 1'b0;
      out_pred_b <= 1'b0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_pred_a <= bim_q;
        out_pred_b <= gsh_q;
        out_sel_b  <= sel_q;
        out_taken  <= sel_q ? gsh_q : bim_q;
      end
    end
  end

  // results follow an accepted request two edges later, and only then
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    acc_p |-> ##2 out_valid);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(acc_p, 2));
  p_idle_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(busy, 2)) |-> !out_valid);

endmodule

// File: tb/tourney_predictor_bench.sv
`timescale 1ns/1ps
module tourney_predictor_bench;
  localparam int SEL_W = 10;
  localparam int BIM_W = 10;
  localparam int GSH_W = BIM_W + 1;
  localparam int ADDR_W = GSH_W;
  localparam int READY_EDGES = 1 << GSH_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pred_valid = 1'b0;
  logic [ADDR_W-1:0] pred_addr = '0;
  logic commit_valid = 1'b0;
  logic [ADDR_W-1:0] commit_addr = '0;
  logic commit_taken = 1'b0;
  logic commit_pred_a = 1'b0;
  logic commit_pred_b = 1'b0;
  logic rdy, out_valid, out_taken, out_sel_b, out_pred_a, out_pred_b;

  always #2 clk = ~clk;

  tourney_predictor #(.SEL_W(SEL_W), .BIM_W(BIM_W)) u_tourney_predictor (
    .clk(clk), .rst(rst),
    .pred_valid(pred_valid), .pred_addr(pred_addr),
    .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_taken(commit_taken), .commit_pred_a(commit_pred_a),
    .commit_pred_b(commit_pred_b),
    .rdy(rdy), .out_valid(out_valid), .out_taken(out_taken),
    .out_sel_b(out_sel_b), .out_pred_a(out_pred_a), .out_pred_b(out_pred_b)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_bim [1 << BIM_W];
  int m_gsh [1 << GSH_W];
  int m_sel [1 << SEL_W];
  int m_hist = 0;
  int edges = 0;
  bit pv_prev = 0, pa_prev = 0, pb_prev = 0, ps_prev = 0, pt_prev = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  // one clock: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic step(input bit pv, input int pad, input bit cv, input int cad,
                      input bit ct, input bit ca, input bit cb);
    bit rdy_pre, nv, na, nb, ns, nt;
    int gi;
    pred_valid = pv; pred_addr = ADDR_W'(pad);
    commit_valid = cv; commit_addr = ADDR_W'(cad);
    commit_taken = ct; commit_pred_a = ca; commit_pred_b = cb;
    rdy_pre = (edges >= READY_EDGES);
    nv = 0; na = 0; nb = 0; ns = 0; nt = 0;
    if (rdy_pre && pv) begin
      nv = 1;
      na = m_bim[pad & ((1 << BIM_W) - 1)] >= 2;
      nb = m_gsh[(pad ^ m_hist) & ((1 << GSH_W) - 1)] >= 2;
      ns = m_sel[pad & ((1 << SEL_W) - 1)] >= 2;
      nt = ns ? nb : na;
    end
    if (rdy_pre && cv) begin
      if (ca != cb) m_sel[cad & ((1 << SEL_W) - 1)] = sat(m_sel[cad & ((1 << SEL_W) - 1)], cb == ct);
      m_bim[cad & ((1 << BIM_W) - 1)] = sat(m_bim[cad & ((1 << BIM_W) - 1)], ct);
      gi = (cad ^ m_hist) & ((1 << GSH_W) - 1);
      m_gsh[gi] = sat(m_gsh[gi], ct);
      m_hist = ((m_hist << 1) | int'(ct)) & ((1 << GSH_W) - 1);
    end
    @(posedge clk);
    edges++;
    @(negedge clk);
    chk(rdy == (edges >= READY_EDGES), "R1 rdy", int'(rdy), int'(edges >= READY_EDGES));
    chk(out_valid == pv_prev, rdy ? "R3 out_valid" : "R2 out_valid", int'(out_valid), int'(pv_prev));
    if (pv_prev && out_valid) begin
      chk(out_pred_a == pa_prev, "R4 out_pred_a", int'(out_pred_a), int'(pa_prev));
      chk(out_pred_b == pb_prev, "R5 out_pred_b", int'(out_pred_b), int'(pb_prev));
      chk(out_sel_b == ps_prev, "R7 out_sel_b", int'(out_sel_b), int'(ps_prev));
      chk(out_taken == pt_prev, "R7 out_taken", int'(out_taken), int'(pt_prev));
    end
    pv_prev = nv; pa_prev = na; pb_prev = nb; ps_prev = ns; pt_prev = nt;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic commit(input int cad, input bit ct, input bit ca, input bit cb);
    step(0, 0, 1, cad, ct, ca, cb);
  endtask

  // request, then one idle step so the result sits on the outputs
  task automatic predict(input int pad);
    step(1, pad, 0, 0, 0, 0, 0);
    idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << BIM_W); i++) m_bim[i] = 1;
    for (int i = 0; i < (1 << GSH_W); i++) m_gsh[i] = 1;
    for (int i = 0; i < (1 << SEL_W); i++) m_sel[i] = 1;
    repeat (3) @(negedge clk);
    chk(rdy == 1'b0, "R1 rdy in reset", int'(rdy), 0);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    // R2: traffic during the sweep is ignored
    for (int i = 0; i < 24; i++)
      step(1, i * 5, 1, i * 5, 1'b1, 1'b0, 1'b1);
    while (edges < READY_EDGES + 2) idle();

    // R1: fresh state, every counter 01, history 0
    predict(16);
    chk(out_pred_a == 0 && out_pred_b == 0 && out_sel_b == 0, "R1 init counters",
        int'({out_pred_a, out_pred_b, out_sel_b}), 0);

    // R8 and R6: one disagreeing commit with B right moves the selector to B
    commit(16, 1, 0, 1);
    predict(16);
    chk(out_sel_b == 1, "R8 selector to B", int'(out_sel_b), 1);
    chk(out_pred_a == 1, "R9 bimodal trained", int'(out_pred_a), 1);
    chk(out_pred_b == 0, "R6 history moved gshare index", int'(out_pred_b), 0);
    chk(out_taken == 0, "R7 final follows B", int'(out_taken), 0);

    // R8 saturation at 3: two more, then one step back still selects B
    commit(16, 1, 0, 1);
    commit(16, 1, 0, 1);
    commit(16, 1, 1, 0);
    predict(16);
    chk(out_sel_b == 1, "R8 saturated then one down", int'(out_sel_b), 1);
    commit(16, 1, 1, 0);
    predict(16);
    chk(out_sel_b == 0, "R8 back to A", int'(out_sel_b), 0);

    // R8: agreement leaves the selector alone
    commit(16, 0, 1, 1);
    commit(16, 0, 1, 1);
    commit(16, 1, 0, 0);
    predict(16);
    chk(out_sel_b == 0, "R8 agree no change", int'(out_sel_b), 0);

    // R9: bimodal saturation at 3 and decrement
    for (int i = 0; i < 5; i++) commit(32, 1, 0, 0);
    commit(32, 0, 0, 0);
    predict(32);
    chk(out_pred_a == 1, "R9 saturated then one down", int'(out_pred_a), 1);
    commit(32, 0, 0, 0);
    predict(32);
    chk(out_pred_a == 0, "R9 two down", int'(out_pred_a), 0);

    // R3: commit at the same edge as the request is not visible to it
    step(1, 128, 1, 128, 1, 0, 0);
    idle();
    chk(out_pred_a == 0, "R3 same-edge commit hidden", int'(out_pred_a), 0);
    predict(128);
    chk(out_pred_a == 1, "R3 commit visible afterwards", int'(out_pred_a), 1);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int a1, a2;
      a1 = int'($urandom_range(0, 7)) * 37;
      a2 = int'($urandom_range(0, 7)) * 37;
      step(bit'($urandom_range(0, 1)), a1, bit'($urandom_range(0, 1)), a2,
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    idle();
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule